// File: doc/BRIEF.md
# Serial-Bus Slave Front End for an 8-Bit Port Expander

This block is the bus-facing half of an 8-bit general-purpose port expander. It watches an I2C clock and data pair that are already synchronised to the system clock. It pulls SDA low through an open-drain enable whenever it must drive a zero. The block answers one 7-bit device address, made of a fixed upper nibble `0100` followed by three strap inputs, so eight expanders can share one bus.

The first byte written after the address is a command byte. It becomes a register pointer into a four-entry register file that sits outside the block: index 0 input, 1 output, 2 polarity, 3 direction. Every later data byte goes to the register the pointer selects, whether it is written or read. The pointer never advances by itself, and it keeps its value across STOP and START until a new command byte arrives. A typical register read is a write of the command byte, a repeated START with the read address, and then one or more data bytes. A read may also start without a command byte and then reads the register already selected.

Writes reach the register file as single-cycle strobes carrying an index and a byte. For every byte sent in read mode, the block pulses a read strobe with the register index. The port logic can use that pulse to snapshot its pins or clear its interrupt.

Top module: `expanderBusSlave`

## Requirements
- R1: The block acknowledges, by pulling SDA low during the 9th clock, only an address byte whose upper seven bits equal `0100` followed by `addrStrap[2:0]` (MSB first). For any other address it leaves SDA released for the rest of the transaction.
- R2: In a write transfer, the first byte after the address loads the pointer. The pointer is acknowledged. Each following data byte to pointer 1, 2 or 3 gives one `wrStrobe` pulse one clock long, with `wrIdx` equal to the pointer and `wrData` equal to the byte. Bits are sent MSB first.
- R3: There is no auto-increment. Several data bytes in one write all go to the same index, and several bytes in one read all come from the same index.
- R4: The pointer keeps its value across STOP and START. A read transfer with no command byte returns the register selected last.
- R5: After a repeated START with the read address, the block drives data MSB first, one bit per SCL low phase. After a master ACK it sends another byte. After a master NACK it sends nothing until the next START.
- R6: For each byte it sends from pointer 0 to 3, the block pulses `rdStrobe` for one clock with `rdIdx` equal to the pointer. The byte sent equals `rdData` as it was when the byte began, before the strobe took effect.
- R7: A data byte written while the pointer is 0 is acknowledged but produces no `wrStrobe`.
- R8: Pointer values 4 to 7 are acknowledged. Data bytes written to them produce no `wrStrobe`. Bytes read from them are 0x00 and produce no `rdStrobe`.
- R9: After reset, SDA is released, neither strobe is high and the pointer is 0 (`rdIdx` = 0).
- R10: A STOP returns the block to idle at any point. A START seen partway through a byte discards that byte without a write. The next transaction after either of these is served normally.
- R11: The block releases SDA after the falling edge that ends the 9th (acknowledge) clock. It changes its SDA drive only while SCL is low or to release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| sclIn | input | 1 | Synchronised bus clock level |
| sdaIn | input | 1 | Synchronised bus data level (wired-AND line) |
| addrStrap | input | 3 | Low three bits of the device address |
| rdData | input | 8 | Register file contents at index `rdIdx` |
| sdaPullLow | output | 1 | 1 = pull SDA low, 0 = release |
| wrStrobe | output | 1 | One-clock register write pulse |
| wrIdx | output | 2 | Register index for the write |
| wrData | output | 8 | Byte to write |
| rdStrobe | output | 1 | One-clock pulse per byte sent from registers 0 to 3 |
| rdIdx | output | 2 | Low bits of the current pointer |

## Verification
All 128 write addresses are swept with a fixed strap value, and every strap value is tried with its matching address. Together these separate the fixed-nibble compare from the strap compare. Every pointer value 0 to 7 is written with a distinct byte, which separates real registers from the silently ignored index 0 and the out-of-range indices. Multi-byte writes and reads, and reads with no command byte, separate a persistent, non-incrementing pointer from one that advances or resets on STOP. The model of register 0 changes its value after every read strobe, which shows whether each byte is sampled at the start of that byte. Transfers cut short by a STOP or a START in the middle of a byte check that the byte is discarded and that the block recovers.

// File: rtl/expanderBusPkg.sv
package expanderBusPkg;
  localparam int DATA_W  = 8;
  localparam int PTR_W   = 3;
  localparam int IDX_W   = 2;
  localparam int STRAP_W = 3;
  localparam logic [3:0] FIXED_ADDR = 4'b0100;

  typedef struct packed {
    logic shiftIn;
    logic shiftOut;
    logic loadPtr;
    logic loadRead;
    logic writeReg;
  } busStrobe_t;
endpackage

// File: rtl/expanderBusData.sv
module expanderBusData
  import expanderBusPkg::*;
#(
  parameter int DW = DATA_W,
  parameter int PW = PTR_W,
  parameter int IW = IDX_W,
  parameter int SW = STRAP_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  busStrobe_t    stb,
  input  logic          sdaIn,
  input  logic [SW-1:0] strap,
  input  logic [DW-1:0] rdData,
  output logic          addrMatch,
  output logic          rwBit,
  output logic          txBit,
  output logic [IW-1:0] ptrIdx,
  output logic          wrStrobe,
  output logic [IW-1:0] wrIdx,
  output logic [DW-1:0] wrData,
  output logic          rdStrobe
);
  logic [DW-1:0] shiftReg;
  logic [PW-1:0] ptr;
  logic ptrInRange;
  logic ptrWritable;

  assign ptrInRange  = (ptr >> IW) == '0;
  assign ptrWritable = ptrInRange && (ptr[IW-1:0] != '0);
  assign addrMatch   = shiftReg[DW-1:1] == {FIXED_ADDR, strap};
  assign rwBit       = shiftReg[0];
  assign txBit       = shiftReg[DW-1];
  assign ptrIdx      = ptr[IW-1:0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftReg <= '0;
      ptr      <= '0;
      wrStrobe <= 1'b0;
      wrIdx    <= '0;
      wrData   <= '0;
      rdStrobe <= 1'b0;
    end else begin
      wrStrobe <= stb.writeReg && ptrWritable;
      rdStrobe <= stb.loadRead && ptrInRange;
      if (stb.writeReg) begin
        wrIdx  <= ptr[IW-1:0];
        wrData <= shiftReg;
      end
      if (stb.loadPtr) ptr <= shiftReg[PW-1:0];
      if (stb.shiftIn)       shiftReg <= {shiftReg[DW-2:0], sdaIn};
      else if (stb.shiftOut) shiftReg <= {shiftReg[DW-2:0], 1'b1};
      else if (stb.loadRead) shiftReg <= ptrInRange ? rdData : '0;
    end
  end
endmodule

// File: rtl/expanderBusCtrl.sv
module expanderBusCtrl
  import expanderBusPkg::*;
#(
  parameter int DW = DATA_W
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  input  logic       addrMatch,
  input  logic       rwBit,
  output busStrobe_t stb,
  output logic       ackDrive,
  output logic       txDrive
);
  localparam int CNT_W = $clog2(DW + 1);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DW);

  typedef enum logic [2:0] {ST_IDLE, ST_ADDR, ST_CMD, ST_WDATA, ST_TX, ST_SKIP} phase_t;

  phase_t st, nextSt;
  logic sclQ, sdaQ, ackSlot, masterNack;
  logic [CNT_W-1:0] bitCnt;
  logic sclRise, sclFall, startSeen, stopSeen, rxState, byteDone, txByteEnd;

  assign sclRise   = sclIn & ~sclQ;
  assign sclFall   = ~sclIn & sclQ;
  assign startSeen = sclQ & sclIn & sdaQ & ~sdaIn;
  assign stopSeen  = sclQ & sclIn & ~sdaQ & sdaIn;
  assign rxState   = (st == ST_ADDR) || (st == ST_CMD) || (st == ST_WDATA);
  assign byteDone  = sclFall && rxState && !ackSlot && (bitCnt == LAST_BIT);
  assign txByteEnd = sclFall && (st == ST_TX) && !ackSlot && (bitCnt == LAST_BIT);

  always_comb begin
    stb.shiftIn  = sclRise && rxState && !ackSlot;
    stb.loadPtr  = byteDone && (st == ST_CMD);
    stb.writeReg = byteDone && (st == ST_WDATA);
    stb.shiftOut = sclFall && (st == ST_TX) && !ackSlot && (bitCnt != LAST_BIT);
    stb.loadRead = sclFall && ackSlot &&
                   ((rxState && nextSt == ST_TX) || (st == ST_TX && !masterNack));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      st         <= ST_IDLE;
      nextSt     <= ST_IDLE;
      sclQ       <= 1'b1;
      sdaQ       <= 1'b1;
      ackSlot    <= 1'b0;
      masterNack <= 1'b0;
      bitCnt     <= '0;
      ackDrive   <= 1'b0;
      txDrive    <= 1'b0;
    end else begin
      sclQ <= sclIn;
      sdaQ <= sdaIn;
      if (startSeen || stopSeen) begin
        st       <= startSeen ? ST_ADDR : ST_IDLE;
        bitCnt   <= '0;
        ackSlot  <= 1'b0;
        ackDrive <= 1'b0;
        txDrive  <= 1'b0;
      end else if (rxState) begin
        if (ackSlot) begin
          if (sclFall) begin
            ackSlot    <= 1'b0;
            ackDrive   <= 1'b0;
            st         <= nextSt;
            bitCnt     <= '0;
            masterNack <= 1'b0;
            txDrive    <= (nextSt == ST_TX);
          end
        end else if (sclRise) begin
          bitCnt <= bitCnt + 1'b1;
        end else if (byteDone) begin
          bitCnt <= '0;
          if (st == ST_ADDR && !addrMatch) begin
            st <= ST_SKIP;
          end else begin
            ackSlot  <= 1'b1;
            ackDrive <= 1'b1;
            if (st == ST_ADDR) nextSt <= rwBit ? ST_TX : ST_CMD;
            else               nextSt <= ST_WDATA;
          end
        end
      end else if (st == ST_TX) begin
        if (ackSlot) begin
          if (sclRise) begin
            masterNack <= sdaIn;
          end else if (sclFall) begin
            ackSlot <= 1'b0;
            if (masterNack) begin
              st <= ST_SKIP;
            end else begin
              txDrive <= 1'b1;
              bitCnt  <= '0;
            end
          end
        end else if (sclRise) begin
          bitCnt <= bitCnt + 1'b1;
        end else if (txByteEnd) begin
          txDrive <= 1'b0;
          ackSlot <= 1'b1;
          bitCnt  <= '0;
        end
      end
    end
  end
endmodule

// File: rtl/expanderBusSlave.sv
module expanderBusSlave
  import expanderBusPkg::*;
#(
  parameter int DW = DATA_W,
  parameter int PW = PTR_W,
  parameter int IW = IDX_W,
  parameter int SW = STRAP_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          sclIn,
  input  logic          sdaIn,
  input  logic [SW-1:0] addrStrap,
  input  logic [DW-1:0] rdData,
  output logic          sdaPullLow,
  output logic          wrStrobe,
  output logic [IW-1:0] wrIdx,
  output logic [DW-1:0] wrData,
  output logic          rdStrobe,
  output logic [IW-1:0] rdIdx
);
  busStrobe_t stb;
  logic addrMatch, rwBit, txBit, ackDrive, txDrive;

  expanderBusCtrl #(.DW(DW)) uCtrl (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .addrMatch(addrMatch), .rwBit(rwBit), .stb(stb),
    .ackDrive(ackDrive), .txDrive(txDrive)
  );

  expanderBusData #(.DW(DW), .PW(PW), .IW(IW), .SW(SW)) uData (
    .clk(clk), .rstN(rstN), .stb(stb), .sdaIn(sdaIn), .strap(addrStrap),
    .rdData(rdData), .addrMatch(addrMatch), .rwBit(rwBit), .txBit(txBit),
    .ptrIdx(rdIdx), .wrStrobe(wrStrobe), .wrIdx(wrIdx), .wrData(wrData),
    .rdStrobe(rdStrobe)
  );

  assign sdaPullLow = ackDrive | (txDrive & ~txBit);
endmodule

// File: rtl/expanderBusChecker.sv
module expanderBusChecker #(
  parameter int IW = 2
) (
  input logic          clk,
  input logic          rstN,
  input logic          sclIn,
  input logic          sdaIn,
  input logic          sdaPullLow,
  input logic          wrStrobe,
  input logic [IW-1:0] wrIdx,
  input logic          rdStrobe
);
  // R7: index 0 is never written
  assert_no_reg0_write_R7: assert property (@(posedge clk) disable iff (!rstN)
    wrStrobe |-> wrIdx != '0);

  // R2: write strobe lasts one clock
  assert_wr_single_R2: assert property (@(posedge clk) disable iff (!rstN)
    wrStrobe |=> !wrStrobe);

  // R6: read strobe lasts one clock and never coincides with a write
  assert_rd_single_R6: assert property (@(posedge clk) disable iff (!rstN)
    rdStrobe |=> !rdStrobe);
  assert_rd_wr_excl_R6: assert property (@(posedge clk) disable iff (!rstN)
    !(rdStrobe && wrStrobe));

  // R10: a STOP releases the line on the next clock
  assert_stop_release_R10: assert property (@(posedge clk) disable iff (!rstN)
    ($past(sclIn) && sclIn && !$past(sdaIn) && sdaIn) |=> !sdaPullLow);

  // R11: drive turns on only while SCL is low
  assert_drive_when_low_R11: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sdaPullLow) |-> !sclIn);
endmodule

bind expanderBusSlave expanderBusChecker #(.IW(IW)) uChk (
  .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
  .sdaPullLow(sdaPullLow), .wrStrobe(wrStrobe), .wrIdx(wrIdx),
  .rdStrobe(rdStrobe)
);

// File: tb/sim_expanderBusSlave.sv
`timescale 1ns/1ps
module sim_expanderBusSlave;
  localparam int Q = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclM = 1'b1;
  logic sdaM = 1'b1;
  logic [2:0] strap = 3'b101;
  logic [7:0] regs [4];
  logic sdaLine, sdaPullLow, wrStrobe, rdStrobe;
  logic [1:0] wrIdx, rdIdx;
  logic [7:0] wrData, rdData;
  int testsRun = 0, testsFailed = 0;
  int wrCount = 0, rdCount = 0;
  logic [1:0] wrIdxLog [64];
  logic [7:0] wrDataLog [64];
  logic [1:0] lastRdIdx;
  bit finished = 0;

  always #2.5 clk = ~clk;

  assign sdaLine = sdaM & ~sdaPullLow;
  assign rdData  = regs[rdIdx];

  expanderBusSlave u0 (
    .clk(clk), .rstN(rstN), .sclIn(sclM), .sdaIn(sdaLine), .addrStrap(strap),
    .rdData(rdData), .sdaPullLow(sdaPullLow), .wrStrobe(wrStrobe), .wrIdx(wrIdx),
    .wrData(wrData), .rdStrobe(rdStrobe), .rdIdx(rdIdx)
  );

  initial begin
    regs[0] = 8'h5A; regs[1] = 8'hFF; regs[2] = 8'h00; regs[3] = 8'hFF;
  end

  // register-file and port model
  always @(posedge clk) begin
    if (wrStrobe) begin
      regs[wrIdx] <= wrData;
      wrIdxLog[wrCount % 64] <= wrIdx;
      wrDataLog[wrCount % 64] <= wrData;
      wrCount <= wrCount + 1;
    end
    if (rdStrobe) begin
      rdCount <= rdCount + 1;
      lastRdIdx <= rdIdx;
      if (rdIdx == 2'd0) regs[0] <= regs[0] + 8'd1;
    end
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic setBus(input logic s, input logic d);
    sclM = s; sdaM = d;
    tick(Q);
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic startCond();
    setBus(sclM, 1'b1); setBus(1'b0, 1'b1); setBus(1'b1, 1'b1);
    setBus(1'b1, 1'b0); setBus(1'b0, 1'b0);
  endtask

  task automatic stopCond();
    setBus(1'b0, 1'b0); setBus(1'b1, 1'b0); setBus(1'b1, 1'b1);
  endtask

  task automatic writeBit(input logic b);
    setBus(1'b0, b); setBus(1'b1, b); setBus(1'b0, b);
  endtask

  task automatic readBit(output logic b);
    setBus(1'b0, 1'b1); setBus(1'b1, 1'b1);
    b = sdaLine;
    setBus(1'b0, 1'b1);
  endtask

  task automatic writeByte(input logic [7:0] v, output bit ack);
    logic b;
    for (int i = 7; i >= 0; i--) writeBit(v[i]);
    readBit(b);
    ack = !b;
  endtask

  task automatic readByte(output logic [7:0] v, input bit masterAck);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      readBit(b);
      v[i] = b;
    end
    writeBit(!masterAck);
  endtask

  logic [7:0] devW, devR;
  assign devW = {4'b0100, strap, 1'b0};
  assign devR = {4'b0100, strap, 1'b1};

  initial begin
    bit a1, a2, a3, a4;
    logic [7:0] v;
    int wc, rc;
    tick(5);
    // R9 reset state
    check(sdaPullLow == 1'b0, "R9 sda released", sdaPullLow, 0);
    check(!wrStrobe && !rdStrobe, "R9 strobes low", {wrStrobe, rdStrobe}, 0);
    check(rdIdx == 2'd0, "R9 pointer zero", rdIdx, 0);
    rstN = 1'b1;
    tick(3);

    // R1 address sweep with strap 101
    for (int a = 0; a < 128; a++) begin
      startCond();
      writeByte({a[6:0], 1'b0}, a1);
      stopCond();
      check(a1 == (a[6:0] == 7'b0100101), "R1 address sweep", a1, a[6:0] == 7'b0100101);
    end
    // R1 strap sweep
    for (int s = 0; s < 8; s++) begin
      strap = s[2:0];
      tick(1);
      startCond();
      writeByte(devW, a1);
      stopCond();
      check(a1, "R1 strap match", a1, 1);
    end
    strap = 3'b101;
    tick(1);

    // R11 release after acknowledge
    startCond();
    writeByte(devW, a1);
    tick(1);
    check(a1 && sdaPullLow == 1'b0, "R11 release after ack", sdaPullLow, 0);
    stopCond();

    // R2 R7 R8 write every pointer value
    for (int k = 0; k < 8; k++) begin
      wc = wrCount;
      startCond();
      writeByte(devW, a1);
      writeByte(k[7:0], a2);
      writeByte(8'hA0 | k[7:0], a3);
      stopCond();
      check(a1 && a2 && a3, (k == 0) ? "R7 ack ptr0" : (k > 3) ? "R8 ack high ptr" : "R2 ack",
            {a1, a2, a3}, 7);
      if (k >= 1 && k <= 3) begin
        check(wrCount == wc + 1, "R2 one write", wrCount - wc, 1);
        check(wrIdxLog[wc % 64] == k[1:0] && wrDataLog[wc % 64] == (8'hA0 | k[7:0]),
              "R2 write idx/data", {wrIdxLog[wc % 64], wrDataLog[wc % 64]}, {k[1:0], 8'hA0 | k[7:0]});
      end else begin
        check(wrCount == wc, (k == 0) ? "R7 no write" : "R8 no write", wrCount - wc, 0);
      end
    end

    // R3 multi-byte write stays on one index
    wc = wrCount;
    startCond();
    writeByte(devW, a1);
    writeByte(8'd2, a2);
    writeByte(8'h11, a3);
    writeByte(8'h22, a4);
    writeByte(8'h33, a4);
    stopCond();
    check(wrCount == wc + 3, "R3 write count", wrCount - wc, 3);
    for (int j = 0; j < 3; j++)
      check(wrIdxLog[(wc + j) % 64] == 2'd2 && wrDataLog[(wc + j) % 64] == 8'(8'h11 * (j + 1)),
            "R3 write log", {wrIdxLog[(wc + j) % 64], wrDataLog[(wc + j) % 64]}, {2'd2, 8'(8'h11 * (j + 1))});

    // R5 R6 command, repeated start, three reads of register 0
    rc = rdCount;
    startCond();
    writeByte(devW, a1);
    writeByte(8'd0, a2);
    startCond();
    writeByte(devR, a3);
    check(a1 && a2 && a3, "R5 acks", {a1, a2, a3}, 7);
    for (int j = 0; j < 3; j++) begin
      readByte(v, j < 2);
      check(v == 8'(8'h5A + j), "R6 snapshot byte", v, 8'(8'h5A + j));
    end
    stopCond();
    check(rdCount == rc + 3 && lastRdIdx == 2'd0, "R6 read strobes", rdCount - rc, 3);
    check(sdaPullLow == 1'b0, "R5 silent after nack", sdaPullLow, 0);

    // R4 pointer persists; R3 no increment on read
    startCond();
    writeByte(devW, a1);
    writeByte(8'd3, a2);
    stopCond();
    rc = rdCount;
    startCond();
    writeByte(devR, a1);
    readByte(v, 1'b1);
    check(v == 8'hA3, "R4 read without command", v, 8'hA3);
    readByte(v, 1'b0);
    check(v == 8'hA3, "R3 read no increment", v, 8'hA3);
    stopCond();
    check(rdCount == rc + 2 && lastRdIdx == 2'd3, "R6 read idx", lastRdIdx, 3);

    // R8 read of high pointer
    startCond();
    writeByte(devW, a1);
    writeByte(8'd6, a2);
    startCond();
    writeByte(devR, a3);
    rc = rdCount;
    readByte(v, 1'b0);
    stopCond();
    check(v == 8'h00, "R8 read zero", v, 0);
    check(rdCount == rc, "R8 no read strobe", rdCount - rc, 0);

    // R10 START mid-byte
    wc = wrCount;
    startCond();
    writeByte(devW, a1);
    writeByte(8'd1, a2);
    for (int j = 0; j < 4; j++) writeBit(j[0]);
    startCond();
    stopCond();
    check(wrCount == wc && regs[1] == 8'hA1, "R10 start mid-byte", wrCount - wc, 0);
    // R10 STOP mid-byte, then recovery
    startCond();
    writeByte(devW, a1);
    writeByte(8'd2, a2);
    for (int j = 0; j < 3; j++) writeBit(1'b0);
    stopCond();
    check(wrCount == wc, "R10 stop mid-byte", wrCount - wc, 0);
    startCond();
    writeByte(devW, a1);
    writeByte(8'd1, a2);
    writeByte(8'h5C, a3);
    stopCond();
    check(a1 && a2 && a3 && wrCount == wc + 1 && regs[1] == 8'h5C, "R10 recovery", regs[1], 8'h5C);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog actual=0x0 expected=0x1");
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end
endmodule